// File: doc/BRIEF.md
# Seven-to-One Four-Lane Pixel Serializer

This block turns a 28-bit pixel word into four serial data lanes, each carrying seven bits per pixel period, plus a fifth lane that carries a forwarded clock pattern. It runs entirely on a bit clock at seven times the pixel rate. A one-cycle framing strobe marks the bit-clock edge that coincides with the pixel clock's rising edge. On that edge the pixel word is captured, and the word captured one period earlier moves into the lane shift registers. Each input bit goes to a fixed, irregular lane and slot position.

A shutdown input turns the outputs off. This is modelled by an output-enable flag that drops one bit clock after shutdown is seen, with every lane driven low. When shutdown is released, a lock-delay counter counts bit clocks up to a parameter value before the data lanes are declared valid. The default count stands for a wait of several microseconds. Inputs with no source are expected to be tied low, so they serialize as zeros.

Top module: `pix_serializer_7to1`

## Requirements
- R1: On a bit-clock edge with `frame_stb` high, `pix_word` is captured. That word appears on the lanes starting at the next strobe edge, so the latency is one pixel period. Slot s of a period is the value shown during the s-th bit clock after the strobe edge, counting from 0.
- R2: Lane 0 (`lane_dat[0]`) sends input bits 1, 0, 7, 6, 4, 3, 2 in slots 0 to 6.
- R3: Lane 1 (`lane_dat[1]`) sends input bits 9, 8, 18, 15, 14, 13, 12 in slots 0 to 6.
- R4: Lane 2 (`lane_dat[2]`) sends input bits 20, 19, 26, 25, 24, 22, 21 in slots 0 to 6.
- R5: Lane 3 (`lane_dat[3]`) sends input bits 5, 27, 23, 17, 16, 11, 10 in slots 0 to 6.
- R6: While `out_en` is high, `lane_clk` is 1 in slots 0 to 3 and 0 in slots 4 to 6. The slot count restarts at 0 on every strobe and otherwise wraps modulo 7. While `out_en` is low, `lane_clk` is 0.
- R7: `out_en` equals the inverse of `shutdown` as sampled at the previous bit-clock edge.
- R8: `data_valid` rises only after `LOCK_CYCLES` consecutive bit-clock edges with `shutdown` low. It falls one edge after `shutdown` is sampled high. While `data_valid` is low, all four data lanes are 0.
- R9: After reset, all outputs are 0 and the capture register holds zero. The first period sent after reset therefore carries all-zero data.
- R10: If no strobe arrives after slot 6, the data lanes send 0 until the next strobe, while the clock lane keeps its 7-slot pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Marks the slot-0 edge; captures the pixel word |
| shutdown | input | 1 | Turns the outputs off and restarts lock |
| pix_word | input | 28 | Parallel pixel word, bits 0 to 27 |
| lane_dat | output | 4 | Serial data lanes 0 to 3 |
| lane_clk | output | 1 | Forwarded clock lane |
| out_en | output | 1 | Output enable (low = off state) |
| data_valid | output | 1 | Lock reached and outputs enabled |

## Verification
A walking-one sequence over all 28 input bits sets a single 1 at a time, so each bit can land in exactly one lane and slot, and any misrouted or swapped position is exposed. Words of all ones, alternating 0101 and 1010, and pseudo-random values check that lanes stay independent and that no slot is stuck. Dropping a strobe separates the zero fill after slot 6 from the free-running clock lane. A shutdown pulse in the middle of a word, followed by a full relock, tests that `out_en`, `data_valid` and the lanes fall at once and that the lock wait starts over.

// File: rtl/pix_serializer_7to1.sv
module pix_serializer_7to1 #(
  parameter int LOCK_CYCLES = 5670
) (
  input  logic        bit_clk,
  input  logic        rst_n,
  input  logic        frame_stb,
  input  logic        shutdown,
  input  logic [27:0] pix_word,
  output logic [3:0]  lane_dat,
  output logic        lane_clk,
  output logic        out_en,
  output logic        data_valid
);
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int HIGH_SLOTS = 4;
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam int SLOT_SRC [LANES*SLOTS] = '{
    1, 0, 7, 6, 4, 3, 2,
    9, 8, 18, 15, 14, 13, 12,
    20, 19, 26, 25, 24, 22, 21,
    5, 27, 23, 17, 16, 11, 10
  };

  logic [27:0]   cap_q;
  logic [2:0]    slot_q;
  logic [CW-1:0] lk_q;
  logic          oe_q;
  logic          locked;

  assign locked = (lk_q == CW'(LOCK_CYCLES));

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      slot_q <= '0;
      lk_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= !shutdown;
      if (shutdown)    lk_q <= '0;
      else if (!locked) lk_q <= lk_q + 1'b1;
      if (frame_stb) begin
        cap_q  <= pix_word;
        slot_q <= '0;
      end else begin
        slot_q <= (slot_q == 3'(SLOTS-1)) ? 3'd0 : 3'(slot_q + 3'd1);
      end
    end
  end

  assign out_en     = oe_q;
  assign data_valid = oe_q & locked;
  assign lane_clk   = oe_q & (slot_q < 3'(HIGH_SLOTS));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOTS-1:0] sh_q;
    always_ff @(posedge bit_clk) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else if (frame_stb) begin
        for (int s = 0; s < SLOTS; s++) sh_q[s] <= cap_q[SLOT_SRC[g*SLOTS+s]];
      end else begin
        sh_q <= {1'b0, sh_q[SLOTS-1:1]};
      end
    end
    assign lane_dat[g] = data_valid & sh_q[0];
  end

  // R1
  capture_word_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_stb |=> cap_q == $past(pix_word));
  // R6
  stb_clk_high_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (frame_stb && !shutdown) |=> lane_clk);
  // R7
  sd_off_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    shutdown |=> !out_en && !lane_clk && lane_dat == 4'd0);
  // R8
  sd_invalid_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    shutdown |=> !data_valid);
  // R8
  lock_restart_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $past(shutdown) |=> !data_valid);
endmodule

// File: tb/pix_serializer_7to1_tb_top.sv
module pix_serializer_7to1_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 20;
  localparam int MAP [28] = '{
    1, 0, 7, 6, 4, 3, 2,
    9, 8, 18, 15, 14, 13, 12,
    20, 19, 26, 25, 24, 22, 21,
    5, 27, 23, 17, 16, 11, 10
  };

  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic shutdown = 1'b0;
  logic [27:0] pix_word = '0;
  logic [3:0] lane_dat;
  logic lane_clk, out_en, data_valid;

  int total = 0;
  int bad = 0;
  string ph = "R9";
  string ltag [4] = '{"R2", "R3", "R4", "R5"};

  int m_cnt, m_pos, m_slot;
  bit m_oe;
  logic [27:0] m_cap, m_cur;

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  pix_serializer_7to1 #(.LOCK_CYCLES(LOCK)) dut_i (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_stb(frame_stb), .shutdown(shutdown),
    .pix_word(pix_word), .lane_dat(lane_dat), .lane_clk(lane_clk),
    .out_en(out_en), .data_valid(data_valid));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit v;
    @(posedge bit_clk);
    if (!rst_n) begin
      m_cnt = 0; m_oe = 0; m_cap = '0; m_cur = '0; m_pos = 7; m_slot = 0;
    end else begin
      m_oe = !shutdown;
      if (shutdown) m_cnt = 0;
      else if (m_cnt < LOCK) m_cnt++;
      if (frame_stb) begin
        m_cur = m_cap; m_cap = pix_word; m_pos = 0; m_slot = 0;
      end else begin
        if (m_pos < 7) m_pos++;
        m_slot = (m_slot + 1) % 7;
      end
    end
    @(negedge bit_clk);
    v = m_oe && (m_cnt == LOCK);
    chk("R7 out_en", int'(out_en), int'(m_oe));
    chk("R8 data_valid", int'(data_valid), int'(v));
    chk("R6 lane_clk", int'(lane_clk), int'(m_oe && m_slot < 4));
    for (int l = 0; l < 4; l++) begin
      bit e;
      e = v && (m_pos < 7) && m_cur[MAP[l*7 + m_pos]];
      chk({ph, "/R1/R8/", ltag[l], " lane data"}, int'(lane_dat[l]), int'(e));
    end
  endtask

  task automatic send(input logic [27:0] w, input int len);
    pix_word = w;
    frame_stb = 1'b1;
    step();
    frame_stb = 1'b0;
    for (int i = 1; i < len; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge bit_clk);
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    ph = "R9";
    for (int i = 0; i < 4; i++) send(28'hFFFFFFF, 7);
    ph = "R1";
    for (int b = 0; b < 28; b++) send(28'h1 << b, 7);
    send(28'hFFFFFFF, 7);
    send(28'h5555555, 7);
    send(28'hAAAAAAA, 7);
    for (int i = 0; i < 10; i++) send(28'($urandom), 7);
    ph = "R10";
    send(28'hFFFFFFF, 14);
    send(28'h0F0F0F0, 7);
    send(28'hFFFFFFF, 10);
    send(28'h1234567, 7);
    ph = "R8";
    send(28'hFFFFFFF, 3);
    shutdown = 1'b1;
    for (int i = 0; i < 9; i++) step();
    shutdown = 1'b0;
    for (int i = 0; i < 5; i++) send(28'($urandom), 7);
    ph = "R1";
    for (int i = 0; i < 6; i++) send(28'($urandom), 7);
    send(28'h0, 7);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule